// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single write requests from synchronous logic into write-enable-timed cycles on an external byte-wide asynchronous static RAM. A request carries an address and a data byte. Once it is accepted, the block pulls chip enable low with the address on the pins for a setup phase. It then lowers write enable and drives the data bus for the pulse phase. It raises write enable again and keeps address and data steady for a hold phase. Where the full cycle time still has not elapsed, it adds recovery cycles before releasing the bus. Output enable stays inactive throughout, so the memory never drives the shared data lines.

All phase lengths are counted in cycles of the block's own clock. They are worked out at elaboration from the clock period in picoseconds and a speed-grade parameter, with every interval rounded up to whole clocks. When the resulting counts cannot cover the grade's minimums, elaboration stops with a fatal message. A ready output tells the requester when a new write may be taken, and a one-cycle done pulse marks the end of each cycle.

Top module: `sram_wr_seq`

## Requirements
- R1: While and directly after reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `req_ready` is 1 and `wr_done` is 0.
- R2: A request is taken at a rising clock edge where `req_valid` and `req_ready` are both 1. From the next cycle on, `req_ready` is 0 until chip enable is high again. `req_ready` is never 1 while chip enable is low.
- R3: After acceptance, chip enable is low with the request's address on `sram_addr` and write enable high for exactly SETUP_CYC cycles (default 1) before write enable falls. Write enable is low only while chip enable is low.
- R4: Write enable stays low for P cycles, where P is the largest of ceil(tWP/T), ceil(tAW/T) - SETUP_CYC and ceil(tDS/T). T is CLK_PS, tWP is the minimum pulse width, tAW is the minimum address-valid-to-write-enable-rise interval, and tDS is the minimum data-valid-to-write-enable-rise interval.
- R5: `sram_dq_oe` is 1 exactly from the cycle write enable falls through the hold phase, and 0 whenever chip enable is high or in setup or recovery. While chip enable is low, `sram_addr` is constant. While `sram_dq_oe` is 1, `sram_dq` is constant and equal to the request's data.
- R6: After write enable rises, chip enable stays low and the data stays driven for H = max(1, ceil(tH/T)) cycles, where tH is the address and data hold minimum.
- R7: Chip enable stays low for max(SETUP_CYC + P + H, ceil(tWC/T)) cycles in total, where tWC is the write cycle time. Any cycles beyond SETUP_CYC + P + H keep write enable high and the data bus released.
- R8: `sram_oe_n` is 1 at all times.
- R9: `wr_done` is 1 for exactly one cycle: the first cycle in which chip enable is high again after a write. At all other times it is 0.
- R10: A request presented while the block is busy is held off, not lost. Requests are written in the order they were accepted, and each appears on the pins with its own address and data.
- R11: GRADE 0 uses tWC 70 ns, tWP 50 ns, tAW 60 ns, tDS 30 ns and tH 5 ns. GRADE 1 uses 85, 60, 70, 35 and 5 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, period CLK_PS |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Address of the requested write |
| req_data | input | DATA_W | Byte to be written |
| req_ready | output | 1 | High when a request can be taken this cycle |
| wr_done | output | 1 | One-cycle pulse after a write cycle ends |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_dq | output | DATA_W | Value for the memory data pins |
| sram_dq_oe | output | 1 | Enable for the external data-bus tristate driver |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low, held high |

## Verification
The assertions assume that the requester honours the ready handshake. That means `req_addr` and `req_data` only matter at an edge where both `req_valid` and `req_ready` are high, and reset stays asserted for at least one clock edge. The stimulus keeps request fields steady while a request waits, and it holds `req_valid` high across busy periods to exercise the hold-off path. The bench runs two instances side by side. One uses the default 20 ns period and the faster grade. The other uses a 1 ns period parameter and the slower grade, so that recovery cycles and a long pulse phase both show up.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_PULSE   = 3'd2,
    PH_HOLD    = 3'd3,
    PH_RECOVER = 3'd4
  } phase_e;

  // Minimum intervals of one speed grade, in picoseconds.
  typedef struct packed {
    int unsigned cycle_ps;      // address valid to next address change
    int unsigned we_low_ps;     // write-enable low width
    int unsigned addr_rise_ps;  // address valid to write-enable rise
    int unsigned data_rise_ps;  // data valid to write-enable rise
    int unsigned hold_ps;       // address/data hold after write-enable rise
  } wr_limits_t;

  function automatic wr_limits_t grade_limits(input int grade);
    wr_limits_t lim;
    if (grade == 0) begin
      lim.cycle_ps     = 70000;
      lim.we_low_ps    = 50000;
      lim.addr_rise_ps = 60000;
      lim.data_rise_ps = 30000;
      lim.hold_ps      = 5000;
    end else begin
      lim.cycle_ps     = 85000;
      lim.we_low_ps    = 60000;
      lim.addr_rise_ps = 70000;
      lim.data_rise_ps = 35000;
      lim.hold_ps      = 5000;
    end
    return lim;
  endfunction

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Write-enable low cycles: the binding one of width, address and data limits.
  function automatic int unsigned pulse_cycles(input int grade, input int unsigned clk_ps,
                                               input int unsigned setup_cyc);
    wr_limits_t  lim;
    int unsigned by_width, by_addr, by_data, addr_total;
    lim        = grade_limits(grade);
    by_width   = ceil_div(lim.we_low_ps, clk_ps);
    addr_total = ceil_div(lim.addr_rise_ps, clk_ps);
    by_addr    = (addr_total > setup_cyc) ? addr_total - setup_cyc : 0;
    by_data    = ceil_div(lim.data_rise_ps, clk_ps);
    return umax(umax(by_width, by_addr), umax(by_data, 1));
  endfunction

  function automatic int unsigned hold_cycles(input int grade, input int unsigned clk_ps);
    wr_limits_t lim;
    lim = grade_limits(grade);
    return umax(ceil_div(lim.hold_ps, clk_ps), 1);
  endfunction

  function automatic int unsigned total_cycles(input int grade, input int unsigned clk_ps,
                                               input int unsigned setup_cyc);
    wr_limits_t  lim;
    int unsigned phases;
    lim    = grade_limits(grade);
    phases = setup_cyc + pulse_cycles(grade, clk_ps, setup_cyc) + hold_cycles(grade, clk_ps);
    return umax(phases, ceil_div(lim.cycle_ps, clk_ps));
  endfunction

  // Independent re-check of the derived counts against the raw minimums.
  function automatic bit counts_cover(input int grade, input int unsigned clk_ps,
                                      input int unsigned setup_cyc, input int unsigned n_pulse,
                                      input int unsigned n_hold, input int unsigned n_total);
    wr_limits_t lim;
    bit ok;
    lim = grade_limits(grade);
    ok  = (setup_cyc >= 1) && (n_pulse >= 1) && (n_hold >= 1);
    ok  = ok && (n_pulse * clk_ps >= lim.we_low_ps);
    ok  = ok && ((setup_cyc + n_pulse) * clk_ps >= lim.addr_rise_ps);
    ok  = ok && (n_pulse * clk_ps >= lim.data_rise_ps);
    ok  = ok && (n_hold * clk_ps >= lim.hold_ps);
    ok  = ok && (n_total * clk_ps >= lim.cycle_ps);
    ok  = ok && (n_total >= setup_cyc + n_pulse + n_hold);
    return ok;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign last = (remain_q == '0);

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int N_SETUP = 1,
  parameter int N_PULSE = 3,
  parameter int N_HOLD  = 1,
  parameter int N_REC   = 0,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             phase_last,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             done_q
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(N_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(N_PULSE - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(N_HOLD - 1);
  localparam logic [CNT_W-1:0] LD_REC   = CNT_W'((N_REC > 0) ? N_REC - 1 : 0);

  phase_e after_hold;

  generate
    if (N_REC > 0) begin : g_with_recover
      assign after_hold = PH_RECOVER;
    end else begin : g_no_recover
      assign after_hold = PH_IDLE;
    end
  endgenerate

  assign accept = (phase_q == PH_IDLE) && req_valid;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (req_valid)  phase_d = PH_SETUP;
      PH_SETUP:   if (phase_last) phase_d = PH_PULSE;
      PH_PULSE:   if (phase_last) phase_d = PH_HOLD;
      PH_HOLD:    if (phase_last) phase_d = after_hold;
      PH_RECOVER: if (phase_last) phase_d = PH_IDLE;
      default:                    phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (phase_d != phase_q);
    unique case (phase_d)
      PH_SETUP:   tmr_val = LD_SETUP;
      PH_PULSE:   tmr_val = LD_PULSE;
      PH_HOLD:    tmr_val = LD_HOLD;
      PH_RECOVER: tmr_val = LD_REC;
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_d == PH_IDLE) && (phase_q != PH_IDLE);
    end
  end

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  phase_e            phase_d,
  output logic [ADDR_W-1:0] pin_addr,
  output logic [DATA_W-1:0] pin_dq,
  output logic              pin_dq_oe,
  output logic              pin_ce_n,
  output logic              pin_we_n
);

  // Pin levels are registered from the next phase so they change together
  // with the phase register and never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_addr  <= '0;
      pin_dq    <= '0;
      pin_dq_oe <= 1'b0;
      pin_ce_n  <= 1'b1;
      pin_we_n  <= 1'b1;
    end else begin
      if (accept) begin
        pin_addr <= req_addr;
        pin_dq   <= req_data;
      end
      pin_ce_n  <= (phase_d == PH_IDLE);
      pin_we_n  <= (phase_d != PH_PULSE);
      pin_dq_oe <= (phase_d == PH_PULSE) || (phase_d == PH_HOLD);
    end
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 20000,
  parameter int GRADE     = 0,
  parameter int SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              wr_done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  localparam int N_SETUP = SETUP_CYC;
  localparam int N_PULSE = int'(pulse_cycles(GRADE, CLK_PS, SETUP_CYC));
  localparam int N_HOLD  = int'(hold_cycles(GRADE, CLK_PS));
  localparam int N_TOTAL = int'(total_cycles(GRADE, CLK_PS, SETUP_CYC));
  localparam int N_REC   = N_TOTAL - N_SETUP - N_PULSE - N_HOLD;
  localparam int N_MAXPH = int'(umax(umax(N_SETUP, N_PULSE), umax(N_HOLD, N_REC)));
  localparam int CNT_W   = $clog2(N_MAXPH + 1);
  localparam bit TIMING_OK = counts_cover(GRADE, CLK_PS, SETUP_CYC, N_PULSE, N_HOLD, N_TOTAL)
                             && (GRADE == 0 || GRADE == 1) && (CLK_PS > 0);

  generate
    if (!TIMING_OK) begin : g_timing_violation
      initial $fatal(1, "sram_wr_seq: derived cycle counts do not cover the grade minimums");
    end
  endgenerate

  phase_e           phase_q;
  phase_e           phase_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             phase_last;
  logic             ev_accept;

  sram_wr_ctrl #(
    .N_SETUP (N_SETUP),
    .N_PULSE (N_PULSE),
    .N_HOLD  (N_HOLD),
    .N_REC   (N_REC),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .phase_last (phase_last),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (ev_accept),
    .done_q     (wr_done)
  );

  sram_wr_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (phase_last)
  );

  sram_wr_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ev_accept),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .phase_d   (phase_d),
    .pin_addr  (sram_addr),
    .pin_dq    (sram_dq),
    .pin_dq_oe (sram_dq_oe),
    .pin_ce_n  (sram_ce_n),
    .pin_we_n  (sram_we_n)
  );

  assign req_ready = (phase_q == PH_IDLE);
  assign sram_oe_n = 1'b1;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int N_SETUP = 1,
  parameter int N_PULSE = 3,
  parameter int N_HOLD  = 1,
  parameter int N_TOTAL = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ev_accept,
  input logic              wr_done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq,
  input logic              sram_dq_oe,
  input logic              sram_ce_n,
  input logic              sram_we_n
);

  logic [15:0] ce_low_cnt;
  logic [15:0] we_low_cnt;
  logic [15:0] hold_cnt;
  logic [15:0] setup_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_low_cnt <= '0;
      we_low_cnt <= '0;
      hold_cnt   <= '0;
      setup_cnt  <= '0;
    end else begin
      ce_low_cnt <= sram_ce_n ? 16'd0 : ce_low_cnt + 16'd1;
      we_low_cnt <= sram_we_n ? 16'd0 : we_low_cnt + 16'd1;
      hold_cnt   <= (sram_we_n && sram_dq_oe) ? hold_cnt + 16'd1 : 16'd0;
      setup_cnt  <= (!sram_ce_n && sram_we_n && !sram_dq_oe) ? setup_cnt + 16'd1 : 16'd0;
    end
  end

  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_ce_n);  // R2
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);  // R2
  AST_ACCEPT_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (!sram_ce_n && sram_we_n));  // R3
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);  // R3
  AST_SETUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> (setup_cnt == 16'(N_SETUP)));  // R3
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt == 16'(N_PULSE)));  // R4
  AST_DRIVE_DURING_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe);  // R5
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> !sram_dq_oe);  // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));  // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq));  // R5
  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_dq_oe) |-> (hold_cnt == 16'(N_HOLD)));  // R6
  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |-> (ce_low_cnt == 16'(N_TOTAL)));  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);  // R9
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $rose(sram_ce_n));  // R9

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .N_SETUP (N_SETUP),
  .N_PULSE (N_PULSE),
  .N_HOLD  (N_HOLD),
  .N_TOTAL (N_TOTAL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ev_accept  (ev_accept),
  .wr_done    (wr_done),
  .sram_addr  (sram_addr),
  .sram_dq    (sram_dq),
  .sram_dq_oe (sram_dq_oe),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n)
);

// File: tb/sram_wr_seq_mon.sv
module sram_wr_seq_mon #(
  parameter string LANE      = "lane",
  parameter int    EXP_SETUP = 1,
  parameter int    EXP_PULSE = 3,
  parameter int    EXP_HOLD  = 1,
  parameter int    EXP_TOTAL = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic [18:0] addr,
  input logic [7:0]  dq,
  input logic        dq_oe,
  input logic        ce_n,
  input logic        we_n,
  input logic        oe_n,
  input logic        done
);

  typedef struct {
    logic [18:0] a;
    logic [7:0]  d;
  } item_t;

  item_t exp_q[$];
  int n_checks = 0;
  int n_fails  = 0;

  int          ce_cnt, we_cnt, hold_cnt, setup_seen;
  logic        prev_ce_n, prev_we_n;
  logic [18:0] addr_first;
  logic [7:0]  data_first;
  bit          bad_stable, bad_drive, bad_oe, bad_done;

  task automatic push(input logic [18:0] a, input logic [7:0] d);
    item_t it;
    it.a = a;
    it.d = d;
    exp_q.push_back(it);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, LANE, act, exp);
    end
  endtask

  task automatic final_checks();
    chk(exp_q.size() == 0, "R10 all accepted writes seen", exp_q.size(), 0);
    chk(!bad_oe, "R8 output enable held high", int'(bad_oe), 0);
    chk(!bad_done, "R9 done only after a cycle", int'(bad_done), 0);
    chk(!bad_drive, "R5 data bus released outside write", int'(bad_drive), 0);
  endtask

  always @(negedge clk) begin
    item_t it;
    if (!rst_n) begin
      ce_cnt = 0; we_cnt = 0; hold_cnt = 0; setup_seen = 0;
      prev_ce_n = 1'b1; prev_we_n = 1'b1;
      bad_stable = 0;
    end else begin
      if (oe_n !== 1'b1) bad_oe = 1;
      if (ce_n && dq_oe) bad_drive = 1;
      if (done && !(ce_n && !prev_ce_n)) bad_done = 1;
      if (!ce_n) begin
        if (prev_ce_n) addr_first = addr;
        else if (addr !== addr_first) bad_stable = 1;
        if (!we_n) begin
          if (!dq_oe) bad_drive = 1;
          if (prev_we_n) begin
            setup_seen = ce_cnt;
            data_first = dq;
            if (exp_q.size() == 0) begin
              chk(0, "R10 unexpected write", 1, 0);
            end else begin
              it = exp_q.pop_front();
              chk(addr === it.a, "R10 write address", int'(addr), int'(it.a));
              chk(dq === it.d, "R10 write data", int'(dq), int'(it.d));
            end
          end else if (dq !== data_first) begin
            bad_stable = 1;
          end
          we_cnt++;
        end else if (we_cnt > 0) begin
          if (dq_oe) begin
            hold_cnt++;
            if (dq !== data_first) bad_stable = 1;
          end
        end else if (dq_oe) begin
          bad_drive = 1;
        end
        ce_cnt++;
      end
      if (ce_n && !prev_ce_n) begin
        chk(setup_seen == EXP_SETUP, "R3 setup cycles", setup_seen, EXP_SETUP);
        chk(we_cnt == EXP_PULSE, "R4 R11 write-enable low cycles", we_cnt, EXP_PULSE);
        chk(hold_cnt == EXP_HOLD, "R6 hold cycles", hold_cnt, EXP_HOLD);
        chk(ce_cnt == EXP_TOTAL, "R7 chip-enable low cycles", ce_cnt, EXP_TOTAL);
        chk(done === 1'b1, "R9 done at cycle end", int'(done), 1);
        chk(!bad_stable, "R5 address and data steady", int'(bad_stable), 0);
        ce_cnt = 0; we_cnt = 0; hold_cnt = 0; setup_seen = 0; bad_stable = 0;
      end
      prev_ce_n = ce_n;
      prev_we_n = we_n;
    end
  end

endmodule

// File: tb/sram_wr_seq_bench.sv
module sram_wr_seq_bench;

  localparam int T0_PS = 20000;
  localparam int T1_PS = 1000;

  // Expected phase lengths, restated by search for the smallest cycle count.
  function automatic int cycles_for(input int ps, input int clk_ps);
    int n = 0;
    while (n * clk_ps < ps) n++;
    return n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_pulse(input int grade, input int clk_ps);
    int wp = (grade == 0) ? 50000 : 60000;
    int aw = (grade == 0) ? 60000 : 70000;
    int ds = (grade == 0) ? 30000 : 35000;
    return imax(imax(cycles_for(wp, clk_ps), cycles_for(aw, clk_ps) - 1), cycles_for(ds, clk_ps));
  endfunction

  function automatic int exp_hold(input int clk_ps);
    return imax(cycles_for(5000, clk_ps), 1);
  endfunction

  function automatic int exp_total(input int grade, input int clk_ps);
    int wc = (grade == 0) ? 70000 : 85000;
    return imax(1 + exp_pulse(grade, clk_ps) + exp_hold(clk_ps), cycles_for(wc, clk_ps));
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10ns clk = ~clk;

  logic        req_valid [2];
  logic [18:0] req_addr  [2];
  logic [7:0]  req_data  [2];
  logic        ready     [2];
  logic        done      [2];
  logic [18:0] s_addr    [2];
  logic [7:0]  s_dq      [2];
  logic        s_dq_oe   [2];
  logic        s_ce_n    [2];
  logic        s_we_n    [2];
  logic        s_oe_n    [2];

  int n_cmp = 0;
  int n_bad = 0;

  sram_wr_seq u_sram_wr_seq (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid[0]), .req_addr (req_addr[0]), .req_data (req_data[0]),
    .req_ready (ready[0]), .wr_done (done[0]),
    .sram_addr (s_addr[0]), .sram_dq (s_dq[0]), .sram_dq_oe (s_dq_oe[0]),
    .sram_ce_n (s_ce_n[0]), .sram_we_n (s_we_n[0]), .sram_oe_n (s_oe_n[0])
  );

  sram_wr_seq #(.CLK_PS (T1_PS), .GRADE (1)) u_sram_wr_seq_fine (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid[1]), .req_addr (req_addr[1]), .req_data (req_data[1]),
    .req_ready (ready[1]), .wr_done (done[1]),
    .sram_addr (s_addr[1]), .sram_dq (s_dq[1]), .sram_dq_oe (s_dq_oe[1]),
    .sram_ce_n (s_ce_n[1]), .sram_we_n (s_we_n[1]), .sram_oe_n (s_oe_n[1])
  );

  sram_wr_seq_mon #(
    .LANE ("grade0"), .EXP_SETUP (1),
    .EXP_PULSE (exp_pulse(0, T0_PS)), .EXP_HOLD (exp_hold(T0_PS)), .EXP_TOTAL (exp_total(0, T0_PS))
  ) u_mon0 (
    .clk (clk), .rst_n (rst_n), .addr (s_addr[0]), .dq (s_dq[0]), .dq_oe (s_dq_oe[0]),
    .ce_n (s_ce_n[0]), .we_n (s_we_n[0]), .oe_n (s_oe_n[0]), .done (done[0])
  );

  sram_wr_seq_mon #(
    .LANE ("grade1"), .EXP_SETUP (1),
    .EXP_PULSE (exp_pulse(1, T1_PS)), .EXP_HOLD (exp_hold(T1_PS)), .EXP_TOTAL (exp_total(1, T1_PS))
  ) u_mon1 (
    .clk (clk), .rst_n (rst_n), .addr (s_addr[1]), .dq (s_dq[1]), .dq_oe (s_dq_oe[1]),
    .ce_n (s_ce_n[1]), .we_n (s_we_n[1]), .oe_n (s_oe_n[1]), .done (done[1])
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge; presents the request, waits for ready,
  // pushes the expected item, and checks that ready drops after the take.
  task automatic send(input int lane, input logic [18:0] a, input logic [7:0] d, input bit keep);
    req_valid[lane] = 1'b1;
    req_addr[lane]  = a;
    req_data[lane]  = d;
    while (!ready[lane]) @(negedge clk);
    if (lane == 0) u_mon0.push(a, d);
    else           u_mon1.push(a, d);
    @(negedge clk);
    chk(ready[lane] == 1'b0, "R2 ready low after accept", int'(ready[lane]), 0);
    if (!keep) req_valid[lane] = 1'b0;
  endtask

  task automatic idle_for(input int lane, input int n);
    req_valid[lane] = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic lane0_run();
    @(negedge clk);
    send(0, 19'h00000, 8'h00, 0);
    idle_for(0, 8);
    send(0, 19'h7FFFF, 8'hFF, 0);
    idle_for(0, 3);
    // back-to-back: requests wait while busy (R10)
    send(0, 19'h12345, 8'hA5, 1);
    send(0, 19'h54321, 8'h5A, 1);
    send(0, 19'h00001, 8'h01, 1);
    send(0, 19'h40000, 8'h80, 0);
    idle_for(0, 1);
    for (int i = 0; i < 4; i++) send(0, 19'(i * 4099), 8'(8'h11 * i + 3), i != 3);
    idle_for(0, 12);
  endtask

  task automatic lane1_run();
    @(negedge clk);
    send(1, 19'h2AAAA, 8'h3C, 0);
    idle_for(1, 5);
    send(1, 19'h55555, 8'hC3, 1);
    send(1, 19'h00FF0, 8'h7E, 0);
    idle_for(1, 100);
  endtask

  task automatic reset_checks();
    for (int l = 0; l < 2; l++) begin
      chk(s_ce_n[l] === 1'b1, "R1 chip enable high", int'(s_ce_n[l]), 1);
      chk(s_we_n[l] === 1'b1 && s_oe_n[l] === 1'b1, "R1 write/output enable high",
          int'({s_we_n[l], s_oe_n[l]}), 3);
      chk(s_dq_oe[l] === 1'b0 && done[l] === 1'b0, "R1 bus released and no done",
          int'({s_dq_oe[l], done[l]}), 0);
      chk(ready[l] === 1'b1, "R1 ready after reset", int'(ready[l]), 1);
    end
  endtask

  initial begin
    for (int l = 0; l < 2; l++) begin
      req_valid[l] = 1'b0;
      req_addr[l]  = '0;
      req_data[l]  = '0;
    end
    repeat (4) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks();
    fork
      begin
        fork
          lane0_run();
          lane1_run();
        join
      end
      begin
        repeat (150000) @(posedge clk);
        chk(0, "R10 watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    u_mon0.final_checks();
    u_mon1.final_checks();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_cmp + u_mon0.n_checks + u_mon1.n_checks,
             n_bad + u_mon0.n_fails + u_mon1.n_fails);
    $finish;
  end

endmodule